// File: doc/BRIEF.md
# LIN Wake-Up Generator with Post-Wake Delimiter

This block produces a wake-up pulse on a LIN transmit line when software asks for one. After the pulse it keeps the next frame from starting until a programmable quiet gap has elapsed. A single-cycle trigger strobe starts the pulse. The transmit line is then held dominant (low) for eight bit times and returns recessive (high). A gap of 3, 7, 31 or 63 bit times follows. All timing comes from a bit-time tick supplied by an external baud generator, so the block counts ticks and never counts clock cycles.

A frame request that arrives during the pulse or the gap is held pending. It is granted on the first bit tick after the gap ends. A stop control forces everything back to idle at once: the pulse and the gap are abandoned, any pending request is discarded and the receive flag is cleared.

The block also watches the receive line for a wake-up sent by another node, meaning a long dominant stretch seen while this node is not driving the line low. When one is found it sets a sticky flag, which software clears by writing 1. The flag drives an interrupt request only when its enable is set.

Top module: `lin_wakeup_gen`

## Requirements
- R1: After reset, tx_line is 1 and busy, frame_grant, rx_wake_flag and rx_wake_irq are all 0.
- R2: A wake_req pulse while idle and not stopped makes busy 1 and tx_line 0 in the next cycle. tx_line stays 0 for exactly 8 bit ticks and is 1 again in the cycle after the 8th tick.
- R3: After the pulse, busy stays 1 with tx_line 1 for a delimiter of N bit ticks, then drops in the cycle after the Nth tick. delim_sel selects N as follows: 0 gives 3, 1 gives 7, 2 gives 31 and 3 gives 63.
- R4: delim_sel is captured in the cycle the wake_req pulse is accepted. Changing it later has no effect on the running delimiter.
- R5: A wake_req pulse that arrives while busy is 1 is ignored. The low time stays 8 ticks and the delimiter length is unchanged.
- R6: A frame_req pulse is held pending while busy. frame_grant then goes 1 for one cycle, in the cycle of the first bit_tick on which busy is 0. When busy is already 0, the grant comes with the next bit_tick and never before it.
- R7: While engine_stop is 1, busy is 0 and tx_line is 1 from the next cycle on, and wake_req is ignored. A pending frame request is discarded, and rx_wake_flag is cleared.
- R8: rx_wake_flag becomes 1 in the cycle after the 5th consecutive bit tick that samples rx_line at 0 while the block is not driving the wake-up pulse. Ticks taken while the pulse is being driven never count towards detection.
- R9: rx_wake_clr at 1 clears rx_wake_flag in the next cycle. When a detection and a clear fall in the same cycle, the flag ends up 1.
- R10: rx_wake_irq is 1 exactly when rx_wake_flag is 1 and rx_wake_ie is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit time from the baud generator |
| wake_req | input | 1 | Wake-up trigger strobe; 1 starts a wake-up, 0 does nothing |
| delim_sel | input | 2 | Delimiter length select (0:3, 1:7, 2:31, 3:63 bit times) |
| engine_stop | input | 1 | 1 holds the engine stopped and idle |
| frame_req | input | 1 | Request to start the next frame |
| rx_line | input | 1 | Serial receive line |
| rx_wake_ie | input | 1 | Interrupt enable for the received-wake-up flag |
| rx_wake_clr | input | 1 | Write-one-to-clear for the received-wake-up flag |
| tx_line | output | 1 | Serial transmit line, 0 = dominant |
| busy | output | 1 | Wake-up pulse or delimiter in progress |
| frame_grant | output | 1 | One-cycle permission for the next frame to start |
| rx_wake_flag | output | 1 | Sticky received-wake-up flag |
| rx_wake_irq | output | 1 | Masked interrupt request |

## Verification
The assertions assume that bit_tick is a single-cycle pulse and that wake_req and frame_req are single-cycle strobes. They also assume that rx_wake_clr is raised only when software intends to clear the flag. The bench issues each tick as one high cycle followed by two low cycles, and pulses every strobe for exactly one cycle at a falling clock edge. In the loop-back case the receive line is wired to follow the transmit line, so the receive input reflects what is really on the bus while this node drives its own pulse.

// File: rtl/lwg_pkg.sv
package lwg_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_PULSE = 2'd1,
    SEQ_GAP   = 2'd2
  } seq_state_t;

  // Delimiter length in bit times for a given select code.
  function automatic int gap_len(input logic [1:0] sel);
    case (sel)
      2'd0:    gap_len = 3;
      2'd1:    gap_len = 7;
      2'd2:    gap_len = 31;
      default: gap_len = 63;
    endcase
  endfunction

  function automatic int max_of(input int a, input int b);
    max_of = (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lwg_seq.sv
module lwg_seq
  import lwg_pkg::*;
#(
  parameter int PULSE_BITS = 8,
  parameter int MAX_GAP    = 63
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       wake_req,
  input  logic [1:0] delim_sel,
  input  logic       engine_stop,
  output logic       pulse_active,
  output logic       gap_active,
  output logic       pulse_done,
  output logic       gap_done
);

  localparam int CNT_W = $clog2(max_of(PULSE_BITS, MAX_GAP) + 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       sel_q;
  logic             pulse_last;
  logic             gap_last;

  assign pulse_last   = (cnt == CNT_W'(PULSE_BITS - 1));
  assign gap_last     = (cnt == CNT_W'(gap_len(sel_q) - 1));
  assign pulse_active = (state == SEQ_PULSE);
  assign gap_active   = (state == SEQ_GAP);
  assign pulse_done   = pulse_active && bit_tick && pulse_last;
  assign gap_done     = gap_active && bit_tick && gap_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
      sel_q <= 2'd0;
    end else if (engine_stop) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (wake_req) begin
            state <= SEQ_PULSE;
            cnt   <= '0;
            sel_q <= delim_sel;
          end
        end
        SEQ_PULSE: begin
          if (bit_tick) begin
            if (pulse_last) begin
              state <= SEQ_GAP;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        SEQ_GAP: begin
          if (bit_tick) begin
            if (gap_last) begin
              state <= SEQ_IDLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lwg_rx_detect.sv
module lwg_rx_detect #(
  parameter int THRESH = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic rx_line,
  input  logic self_driving,
  input  logic engine_stop,
  input  logic flag_clr,
  output logic wake_seen,
  output logic wake_flag
);

  localparam int RUN_W = $clog2(THRESH + 1);

  logic [RUN_W-1:0] run;
  logic             dom_tick;

  assign dom_tick  = bit_tick && !rx_line && !self_driving;
  assign wake_seen = dom_tick && (run == RUN_W'(THRESH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0;
    end else if (engine_stop) begin
      run <= '0;
    end else if (dom_tick) begin
      if (run != RUN_W'(THRESH)) run <= run + 1'b1;
    end else if (bit_tick) begin
      run <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_flag <= 1'b0;
    end else if (engine_stop) begin
      wake_flag <= 1'b0;
    end else begin
      wake_flag <= (wake_flag && !flag_clr) || wake_seen;
    end
  end

endmodule

// File: rtl/lwg_grant.sv
module lwg_grant (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic frame_req,
  input  logic seq_busy,
  input  logic engine_stop,
  output logic frame_grant
);

  logic pend;

  assign frame_grant = pend && bit_tick && !seq_busy && !engine_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (engine_stop) begin
      pend <= 1'b0;
    end else begin
      pend <= (pend && !frame_grant) || frame_req;
    end
  end

endmodule

// File: rtl/lin_wakeup_gen.sv
module lin_wakeup_gen #(
  parameter int PULSE_BITS = 8,
  parameter int MAX_GAP    = 63,
  parameter int RX_THRESH  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       wake_req,
  input  logic [1:0] delim_sel,
  input  logic       engine_stop,
  input  logic       frame_req,
  input  logic       rx_line,
  input  logic       rx_wake_ie,
  input  logic       rx_wake_clr,
  output logic       tx_line,
  output logic       busy,
  output logic       frame_grant,
  output logic       rx_wake_flag,
  output logic       rx_wake_irq
);

  logic pulse_active;
  logic gap_active;
  logic pulse_done;
  logic gap_done;
  logic wake_seen;

  lwg_seq #(
    .PULSE_BITS (PULSE_BITS),
    .MAX_GAP    (MAX_GAP)
  ) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (bit_tick),
    .wake_req     (wake_req),
    .delim_sel    (delim_sel),
    .engine_stop  (engine_stop),
    .pulse_active (pulse_active),
    .gap_active   (gap_active),
    .pulse_done   (pulse_done),
    .gap_done     (gap_done)
  );

  lwg_grant grant_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .frame_req   (frame_req),
    .seq_busy    (busy),
    .engine_stop (engine_stop),
    .frame_grant (frame_grant)
  );

  lwg_rx_detect #(
    .THRESH (RX_THRESH)
  ) rxd_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (bit_tick),
    .rx_line      (rx_line),
    .self_driving (pulse_active),
    .engine_stop  (engine_stop),
    .flag_clr     (rx_wake_clr),
    .wake_seen    (wake_seen),
    .wake_flag    (rx_wake_flag)
  );

  assign tx_line     = !pulse_active;
  assign busy        = pulse_active || gap_active;
  assign rx_wake_irq = rx_wake_flag && rx_wake_ie;

endmodule

// File: rtl/lwg_checker.sv
module lwg_checker (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic wake_req,
  input logic engine_stop,
  input logic rx_line,
  input logic rx_wake_clr,
  input logic tx_line,
  input logic busy,
  input logic frame_grant,
  input logic rx_wake_flag,
  input logic pulse_done
);

  AST_TX_LOW_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_line |-> busy); // R2

  AST_WAKE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wake_req && !engine_stop) |=> (busy && !tx_line)); // R2

  AST_PULSE_TO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_done && !engine_stop) |=> (tx_line && busy)); // R3

  AST_GRANT_ON_IDLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    frame_grant |-> (bit_tick && !busy)); // R6

  AST_STOP_FORCES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    engine_stop |=> (!busy && tx_line && !rx_wake_flag)); // R7

  AST_FLAG_NEEDS_DOMINANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_wake_flag) |-> $past(!rx_line)); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wake_flag && !rx_wake_clr && !engine_stop) |=> rx_wake_flag); // R9

endmodule

bind lin_wakeup_gen lwg_checker chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_tick     (bit_tick),
  .wake_req     (wake_req),
  .engine_stop  (engine_stop),
  .rx_line      (rx_line),
  .rx_wake_clr  (rx_wake_clr),
  .tx_line      (tx_line),
  .busy         (busy),
  .frame_grant  (frame_grant),
  .rx_wake_flag (rx_wake_flag),
  .pulse_done   (pulse_done)
);

// File: tb/lin_wakeup_gen_tb_top.sv
`timescale 1ns/1ps
module lin_wakeup_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       wake_req = 1'b0;
  logic [1:0] delim_sel = 2'd0;
  logic       engine_stop = 1'b0;
  logic       frame_req = 1'b0;
  logic       rx_force = 1'b1;
  logic       rx_wake_ie = 1'b0;
  logic       rx_wake_clr = 1'b0;
  logic       rx_line;
  logic       tx_line, busy, frame_grant, rx_wake_flag, rx_wake_irq;

  int n_run = 0;
  int n_fail = 0;
  int grant_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign rx_line = tx_line & rx_force;

  lin_wakeup_gen dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (bit_tick),
    .wake_req     (wake_req),
    .delim_sel    (delim_sel),
    .engine_stop  (engine_stop),
    .frame_req    (frame_req),
    .rx_line      (rx_line),
    .rx_wake_ie   (rx_wake_ie),
    .rx_wake_clr  (rx_wake_clr),
    .tx_line      (tx_line),
    .busy         (busy),
    .frame_grant  (frame_grant),
    .rx_wake_flag (rx_wake_flag),
    .rx_wake_irq  (rx_wake_irq)
  );

  always @(posedge clk) if (frame_grant) grant_cnt <= grant_cnt + 1;

  // {start select, select after start, retrigger, expected delimiter ticks}
  localparam logic [11:0] VEC [0:4] = '{
    {2'd0, 2'd3, 1'b0, 7'd3},
    {2'd1, 2'd2, 1'b1, 7'd7},
    {2'd2, 2'd0, 1'b0, 7'd31},
    {2'd3, 2'd1, 1'b1, 7'd63},
    {2'd0, 2'd0, 1'b1, 7'd3}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_wake();
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
  endtask

  task automatic pulse_frame();
    frame_req = 1'b1;
    @(negedge clk);
    frame_req = 1'b0;
  endtask

  task automatic run_to_idle();
    for (int k = 0; k < 200 && busy; k++) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int gc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(tx_line == 1'b1, "R1 tx_line", tx_line, 1);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(frame_grant == 1'b0, "R1 frame_grant", frame_grant, 0);
    chk(rx_wake_flag == 1'b0 && rx_wake_irq == 1'b0, "R1 flag/irq", rx_wake_flag, 0);

    // Vector walk: R2 pulse length, R3 delimiter, R4 capture, R5 retrigger
    for (int v = 0; v < 5; v++) begin
      int low_n, gap_n;
      logic [11:0] e;
      e = VEC[v];
      low_n = 0;
      gap_n = 0;
      delim_sel = e[11:10];
      pulse_wake();
      delim_sel = e[9:8];
      chk(busy && !tx_line, "R2 start", {30'd0, busy, tx_line}, 2);
      for (int n = 0; n < 200 && busy; n++) begin
        if (e[7] && (n == 3 || n == 12)) pulse_wake();
        if (!tx_line) low_n++;
        else gap_n++;
        tick();
      end
      chk(low_n == 8, "R2/R5 low ticks", low_n, 8);
      chk(gap_n == int'(e[6:0]), "R3/R4/R5 delimiter ticks", gap_n, int'(e[6:0]));
      chk(tx_line && !busy, "R3 idle after delimiter", busy, 0);
    end

    // R6 pending frame during wake-up
    gc = grant_cnt;
    delim_sel = 2'd0;
    pulse_wake();
    tick();
    tick();
    pulse_frame();
    run_to_idle();
    chk(grant_cnt == gc, "R6 no grant while busy", grant_cnt, gc);
    bit_tick = 1'b1;
    #1;
    chk(frame_grant == 1'b1, "R6 grant on first idle tick", frame_grant, 1);
    @(negedge clk);
    bit_tick = 1'b0;
    @(negedge clk);
    chk(grant_cnt == gc + 1, "R6 single grant", grant_cnt, gc + 1);
    pulse_frame();
    repeat (3) @(negedge clk);
    chk(grant_cnt == gc + 1, "R6 idle request waits for tick", grant_cnt, gc + 1);
    tick();
    chk(grant_cnt == gc + 2, "R6 idle request granted on tick", grant_cnt, gc + 2);

    // R7 stop aborts and discards pending request
    delim_sel = 2'd3;
    pulse_wake();
    repeat (4) tick();
    pulse_frame();
    tick();
    tick();
    engine_stop = 1'b1;
    @(negedge clk);
    chk(!busy && tx_line, "R7 abort to idle", busy, 0);
    pulse_wake();
    @(negedge clk);
    chk(!busy && tx_line, "R7 wake ignored while stopped", busy, 0);
    engine_stop = 1'b0;
    gc = grant_cnt;
    repeat (3) tick();
    chk(grant_cnt == gc, "R7 pending discarded", grant_cnt, gc);
    chk(!busy, "R7 stays idle", busy, 0);

    // R8 own pulse seen on rx through loop-back is not a detection
    delim_sel = 2'd0;
    pulse_wake();
    run_to_idle();
    chk(rx_wake_flag == 1'b0, "R8 own pulse ignored", rx_wake_flag, 0);
    rx_force = 1'b0;
    repeat (4) tick();
    chk(rx_wake_flag == 1'b0, "R8 four ticks not enough", rx_wake_flag, 0);
    tick();
    chk(rx_wake_flag == 1'b1, "R8 fifth tick detects", rx_wake_flag, 1);
    rx_force = 1'b1;

    // R10 masking
    rx_wake_ie = 1'b0;
    @(negedge clk);
    chk(rx_wake_irq == 1'b0, "R10 masked", rx_wake_irq, 0);
    rx_wake_ie = 1'b1;
    @(negedge clk);
    chk(rx_wake_irq == 1'b1, "R10 enabled", rx_wake_irq, 1);

    // R9 clear, then set wins over clear
    rx_wake_clr = 1'b1;
    @(negedge clk);
    rx_wake_clr = 1'b0;
    chk(rx_wake_flag == 1'b0, "R9 cleared", rx_wake_flag, 0);
    chk(rx_wake_irq == 1'b0, "R10 irq follows flag", rx_wake_irq, 0);
    tick();
    rx_force = 1'b0;
    repeat (4) tick();
    bit_tick = 1'b1;
    rx_wake_clr = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    rx_wake_clr = 1'b0;
    chk(rx_wake_flag == 1'b1, "R9 set beats clear", rx_wake_flag, 1);
    rx_force = 1'b1;
    tick();

    // R7 stop clears the flag
    engine_stop = 1'b1;
    @(negedge clk);
    chk(rx_wake_flag == 1'b0, "R7 stop clears flag", rx_wake_flag, 0);
    engine_stop = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule